// File: doc/BRIEF.md
# Chainable Serial Register Slave

This block is the serial front end of a small register file. A host drives a serial clock, an active-low select and a data line. While the select is low, every rising serial-clock edge shifts one bit into a 16-bit shift register. When the select returns high, the shift register's contents are decoded as one command. A command with the top bit clear stores its low byte in the addressed 8-bit register. A command with the top bit set copies the addressed register into the low byte of the shift register, so that the next transfer carries it out.

The serial output presents the shift register's most significant bit and changes on falling serial-clock edges. It also takes that bit when the select rises. Several slaves can share the serial clock and the select, with each slave's output wired to the next slave's input. All slaves in such a chain then latch together at the end of one long transfer.

The three serial inputs are brought into the system-clock domain through synchronizer flops, and their edges are detected there. The system clock must run at least four times faster than the serial clock.

Top module: `spi_rf_slave`

## Requirements
- R1: A command is the last 16 bits shifted in, most significant bit first. Bit 15 is the direction (0 = store), bits 14..8 are a 7-bit address and bits 7..0 a data byte. A store to address a < NUM_REGS sets register a, which appears on regs_o bits [8a+7:8a].
- R2: After reset, every register reads 0x00, dout_o is 0 and the shift register is all zeros.
- R3: A frame may have any number of bits. On select rising, the command is taken from the last 16 bits received, which may include bits left over from earlier frames.
- R4: When bit 15 of a command is 1 (fetch), select rising replaces shift-register bits 7..0 with the addressed register. The next transfer then emits the command byte followed by the register byte.
- R5: While the select is low, dout_o takes the shift register's top bit on each falling serial-clock edge, so a bit reaches dout_o 15.5 serial clocks after it enters. dout_o also takes that bit when the select rises, and otherwise holds its value.
- R6: The select may rise while the serial clock is still high after the last bit, or after the clock has gone low. Both cases latch the same command and give the same dout_o.
- R7: Serial-clock edges while the select is high change neither the shift register nor dout_o.
- R8: A store to an address at or above NUM_REGS changes no register. A fetch from such an address loads 0x00.
- R9: With n slaves chained output-to-input on a shared clock and select, a 16·n-bit transfer delivers the last 16 bits to the first slave, each earlier 16-bit group to the slave one step further down the chain, and every slave latches at the same select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low select; its rising edge latches the command |
| din_i | input | 1 | Serial data in, sampled on serial-clock rise |
| dout_o | output | 1 | Serial data out, updated on serial-clock fall |
| regs_o | output | NUM_REGS*8 | Register contents, register k in byte k |

## Verification
The bench builds two instances with NUM_REGS = 4 and SYNC_STAGES = 2. The first instance's output drives the second instance's input, forming a real two-slave chain. With only four registers, almost all of the 7-bit address space is unimplemented, so stores and fetches to absent addresses are easy to reach. The chain puts 32-bit transfers, read-back through a neighbour, and frames of 8 and 24 bits within reach of a single run.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef logic [FRAME_W-1:0] shreg_t;
endpackage

// File: rtl/spi_rf_sync_cell.sv
module spi_rf_sync_cell #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_rf_front.sv
module spi_rf_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic din_i,
  output logic shift_o,
  output logic fall_o,
  output logic latch_o,
  output logic bit_o
);
  localparam int NSIG = 3;
  // lane 0 = sclk, lane 1 = select (idle high), lane 2 = data
  localparam logic [NSIG-1:0] LANE_RST = 3'b010;

  logic [NSIG-1:0] raw, syn;
  logic            sclk_q, cs_q;

  assign raw = {din_i, cs_ni, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    spi_rf_sync_cell #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(LANE_RST[g])
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (syn[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= syn[0];
      cs_q   <= syn[1];
    end
  end

  assign shift_o = syn[0] & ~sclk_q & ~syn[1];
  assign fall_o  = ~syn[0] & sclk_q & ~syn[1];
  assign latch_o = syn[1] & ~cs_q;
  assign bit_o   = syn[2];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              fall_i,
  input  logic              latch_i,
  input  logic              bit_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_byte_i,
  output shreg_t            shreg_o,
  output logic              dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o <= '0;
    end else if (shift_i) begin
      shreg_o <= {shreg_o[FRAME_W-2:0], bit_i};
    end else if (load_i) begin
      shreg_o[DATA_W-1:0] <= load_byte_i;
    end
  end

  // msb out on fall, and again at latch for a select that rises with sclk high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dout_o <= 1'b0;
    else if (fall_i || latch_i) dout_o <= shreg_o[FRAME_W-1];
  end

  a_r3_bit_enters_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> shreg_o[0] == $past(bit_i));

  a_r7_hold_without_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(shreg_o));

  a_r5_dout_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !latch_i) |=> $stable(dout_o));
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))     mem_q[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];

    a_r1_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == ADDR_W'(g)) |=> mem_q[g] == $past(wdata_i));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = mem_q[i];
  end

  a_r8_unmapped_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && {1'b0, waddr_i} >= LIMIT) |=> $stable(regs_o));
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       din_i,
  output logic                       dout_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic              shift, fall, latch, sbit;
  logic              we, load;
  logic [DATA_W-1:0] rdata;
  shreg_t            shreg;
  frame_t            cmd;

  spi_rf_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .cs_ni  (cs_ni),
    .din_i  (din_i),
    .shift_o(shift),
    .fall_o (fall),
    .latch_o(latch),
    .bit_o  (sbit)
  );

  assign cmd  = frame_t'(shreg);
  assign we   = latch & ~cmd.rd;
  assign load = latch & cmd.rd;

  spi_rf_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .fall_i     (fall),
    .latch_i    (latch),
    .bit_i      (sbit),
    .load_i     (load),
    .load_byte_i(rdata),
    .shreg_o    (shreg),
    .dout_o     (dout_o)
  );

  spi_rf_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(cmd.addr),
    .wdata_i(cmd.data),
    .raddr_i(cmd.addr),
    .rdata_o(rdata),
    .regs_o (regs_o)
  );

  a_r4_fetch_loads_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> shreg[DATA_W-1:0] == $past(rdata));

  a_r4_fetch_keeps_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> shreg[FRAME_W-1:DATA_W] == $past(shreg[FRAME_W-1:DATA_W]));

  a_r1_no_store_on_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> $stable(regs_o));
endmodule

// File: tb/spi_rf_slave_test.sv
module spi_rf_slave_test;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout0, dout1;
  logic [NR*8-1:0] regs0, regs1;

  always #2 clk = ~clk;

  spi_rf_slave #(.NUM_REGS(NR), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .din_i(din), .dout_o(dout0), .regs_o(regs0));

  spi_rf_slave #(.NUM_REGS(NR), .SYNC_STAGES(2)) uut_next (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .din_i(dout0), .dout_o(dout1), .regs_o(regs1));

  // behavioural model of both slaves
  logic [15:0] ms [2];
  logic        md [2];
  logic [7:0]  mr [2][NR];

  int n_chk = 0, n_fail = 0, settle = 8, cyc = 0;
  bit run = 1'b0, done = 1'b0;
  logic [63:0] cap0 = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] mflat(input int d);
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[k*8 +: 8] = mr[d][k];
    return v;
  endfunction

  function automatic void m_rise();
    logic b1;
    b1 = md[0];
    ms[0] = {ms[0][14:0], din};
    ms[1] = {ms[1][14:0], b1};
  endfunction

  function automatic void m_fall();
    for (int d = 0; d < 2; d++) md[d] = ms[d][15];
  endfunction

  function automatic void m_csr();
    for (int d = 0; d < 2; d++) begin
      logic [6:0] a;
      a = ms[d][14:8];
      md[d] = ms[d][15];
      if (ms[d][15]) ms[d][7:0] = (a < NR) ? mr[d][a[1:0]] : 8'h00;
      else if (a < NR) mr[d][a[1:0]] = ms[d][7:0];
    end
  endfunction

  task automatic step();
    settle = 3;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] bits, input int n, input bit hi_end);
    cs_n = 1'b0; step();
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i]; step();
      cap0 = {cap0[62:0], dout0};
      sclk = 1'b1; m_rise(); step();
      if (i == 0 && hi_end) begin
        cs_n = 1'b1; m_csr(); step();
        sclk = 1'b0; step();
      end else begin
        sclk = 1'b0; m_fall(); step();
      end
    end
    if (!hi_end) begin
      cs_n = 1'b1; m_csr(); step();
    end
  endtask

  task automatic finish_sim();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // per-clock comparison once the synchronizer latency has passed
  always @(posedge clk) begin
    #1;
    if (run && !done) begin
      if (settle > 0) settle--;
      else begin
        chk("R5 dout slave0", {31'b0, dout0}, {31'b0, md[0]});
        chk("R5 dout slave1", {31'b0, dout1}, {31'b0, md[1]});
        chk("R1 regs slave0", regs0, mflat(0));
        chk("R9 regs slave1", regs1, mflat(1));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_sim();
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      ms[d] = '0; md[d] = 1'b0;
      for (int k = 0; k < NR; k++) mr[d][k] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R2 reset dout0", {31'b0, dout0}, 32'h0);
    chk("R2 reset regs0", regs0, 32'h0);
    chk("R2 reset regs1", regs1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    step();

    send(64'h01A5, 16, 1'b0);
    chk("R1 store reg1", {24'b0, regs0[15:8]}, 32'hA5);

    send({32'b0, 16'h025A, 16'h03C3}, 32, 1'b0);
    chk("R9 near slave reg3", {24'b0, regs0[31:24]}, 32'hC3);
    chk("R9 near slave reg2 untouched", {24'b0, regs0[23:16]}, 32'h00);
    chk("R9 far slave reg2", {24'b0, regs1[23:16]}, 32'h5A);

    send(64'h8100, 16, 1'b0);
    send(64'h003C, 16, 1'b0);
    chk("R4 fetch stream", {16'b0, cap0[15:0]}, 32'h81A5);
    chk("R1 store reg0", {24'b0, regs0[7:0]}, 32'h3C);

    send(64'h4577, 16, 1'b0);
    chk("R8 unmapped store", regs0, 32'hC300A53C);
    send(64'hC500, 16, 1'b0);
    send(64'h7F00, 16, 1'b0);
    chk("R8 unmapped fetch", {16'b0, cap0[15:0]}, 32'hC500);

    send(64'hFF0111, 24, 1'b0);
    chk("R3 long frame", {24'b0, regs0[15:8]}, 32'h11);
    send(64'h7F02, 16, 1'b0);
    send(64'h33, 8, 1'b0);
    chk("R3 short frame", {24'b0, regs0[23:16]}, 32'h33);

    send(64'h0099, 16, 1'b1);
    chk("R6 select rise with sclk high", {24'b0, regs0[7:0]}, 32'h99);
    send(64'h8000, 16, 1'b1);
    send(64'h7F00, 16, 1'b0);
    chk("R6 fetch with sclk high", {16'b0, cap0[15:0]}, 32'h8099);

    send(64'h7F01, 16, 1'b0);
    din = 1'b1;
    for (int p = 0; p < 5; p++) begin
      sclk = 1'b1; step();
      sclk = 1'b0; step();
    end
    chk("R7 dout held while idle", {31'b0, dout0}, 32'h0);
    chk("R7 regs held while idle", regs0, 32'hC3331199);
    send(64'h66, 8, 1'b0);
    chk("R7 idle clocks ignored", {24'b0, regs0[15:8]}, 32'h66);

    send(64'hFF00, 16, 1'b0);
    chk("R5 dout shows msb after latch", {31'b0, dout0}, 32'h1);
    send(64'h7F00, 16, 1'b0);
    chk("R5 stream out", {16'b0, cap0[15:0]}, 32'hFF00);

    step();
    finish_sim();
  end
endmodule